// File: doc/BRIEF.md
# Segmented Phase-Enabled Shift Register

This block is a long serial shift register split into short segments. Each segment holds a few data bits plus one extra bridge bit that carries a value over to the next segment. Every storage element is a register on the fast system clock. It loads only in a cycle where its own phase enable is high.

Five phase enables are shared by all segments. One complete shift step applies them in reverse data-flow order:

1. The bridge bits capture their segment's last data bit.
2. The data bits move from the last one towards the first.
3. The first bit of each segment loads its head input. For the first segment this is the serial input; for every later segment it is the previous segment's bridge bit.

Because every element is written only after its successor has already taken the old value, each element sees a stable source while it loads. The register file is 512 bits by default, built as 128 segments of four bits. All data bits are visible on a parallel bus, and the oldest bit drives the serial output.

Top module: `seg_shift_chain`

## Requirements
- R1: Data bit i (0 = head) of segment s appears on `par_out[SEG_BITS*s + i]`. `ser_out` equals the top bit of `par_out`, which is the last data bit of the last segment.
- R2: `phase_en` has SEG_BITS+1 bits, and at most one of them may be high in any clock cycle. Each element loads at a rising clock edge only if its own enable bit is high.
- R3: When `phase_en[0]` is high, every bridge bit takes its segment's last data bit (index SEG_BITS-1), and no data bit changes.
- R4: When `phase_en[k]` is high for k in 1..SEG_BITS-1, data bit SEG_BITS-k of every segment takes data bit SEG_BITS-k-1 of the same segment. No other bit changes.
- R5: When `phase_en[SEG_BITS]` is high, data bit 0 of segment 0 takes `ser_in`, and data bit 0 of each later segment takes the bridge bit of the segment before it.
- R6: Pulsing `phase_en[0]`, `phase_en[1]`, … `phase_en[SEG_BITS]` in that order, with idle cycles allowed in between, shifts the whole chain by one position: `par_out` becomes `{par_out[TOTAL-2:0], ser_in}`, where `ser_in` is the value present in the head-phase cycle.
- R7: In a cycle with all enables low, every bit holds its value, whatever `ser_in` does.
- R8: Synchronous reset clears all data bits and all bridge bits to 0 and takes priority over any enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into segment 0 |
| phase_en | input | SEG_BITS+1 | Phase enables; bit 0 = bridge capture, bit SEG_BITS = head capture |
| par_out | output | SEG_BITS*NUM_SEGS | All data bits, segment-major |
| ser_out | output | 1 | Oldest data bit of the chain |

## Verification
Reset and the head-capture phase can fall in the same cycle, and both would write the segment heads. The bench provokes this after a bridge capture has loaded nonzero bridge bits. It raises reset together with `phase_en[SEG_BITS]` and `ser_in` = 1, and requires `par_out` to read all zero. It then fires a lone head phase and requires only bit 0 to become 1. This second check proves that the bridges were cleared as well, not merely the visible data bits.

// File: rtl/seg_shift_pkg.sv
package seg_shift_pkg;
    // Phase index of the bridge capture; always the first pulse of a step.
    localparam int BRIDGE_PHASE = 0;

    // Phase index that loads data bit idx of a segment with seg_bits data bits.
    function automatic int data_phase(input int seg_bits, input int idx);
        return seg_bits - idx;
    endfunction
endpackage

// File: rtl/seg_en_reg.sv
module seg_en_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/seg_unit.sv
module seg_unit
    import seg_shift_pkg::*;
#(
    parameter int SEG_BITS = 4,
    localparam int PH_W    = SEG_BITS + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PH_W-1:0]     phase_en,
    input  logic                head_in,
    output logic [SEG_BITS-1:0] data_q,
    output logic                bridge_q
);
    logic [SEG_BITS-1:0] src;

    for (genvar i = 0; i < SEG_BITS; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign src[i] = head_in;
        end else begin : g_body
            assign src[i] = data_q[i-1];
        end
        seg_en_reg #(.WIDTH(1)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .load (phase_en[data_phase(SEG_BITS, i)]),
            .d    (src[i]),
            .q    (data_q[i])
        );
    end

    seg_en_reg #(.WIDTH(1)) u_bridge (
        .clk  (clk),
        .rst  (rst),
        .load (phase_en[BRIDGE_PHASE]),
        .d    (data_q[SEG_BITS-1]),
        .q    (bridge_q)
    );
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
    parameter int SEG_BITS = 4,
    parameter int NUM_SEGS = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_in,
    input  logic [SEG_BITS:0]            phase_en,
    output logic [SEG_BITS*NUM_SEGS-1:0] par_out,
    output logic                         ser_out
);
    localparam int TOTAL = SEG_BITS * NUM_SEGS;

    logic [NUM_SEGS-1:0] bridge;

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        logic head;
        if (s == 0) begin : g_first
            assign head = ser_in;
        end else begin : g_next
            assign head = bridge[s-1];
        end
        seg_unit #(.SEG_BITS(SEG_BITS)) u_seg (
            .clk      (clk),
            .rst      (rst),
            .phase_en (phase_en),
            .head_in  (head),
            .data_q   (par_out[s*SEG_BITS +: SEG_BITS]),
            .bridge_q (bridge[s])
        );
    end

    assign ser_out = par_out[TOTAL-1];
endmodule

// File: rtl/seg_shift_chain_chk.sv
module seg_shift_chain_chk #(
    parameter int SEG_BITS = 4,
    parameter int NUM_SEGS = 128
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         ser_in,
    input logic [SEG_BITS:0]            phase_en,
    input logic [SEG_BITS*NUM_SEGS-1:0] par_out,
    input logic                         ser_out,
    input logic [NUM_SEGS-1:0]          bridge
);
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_en)); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (par_out == '0) && (bridge == '0)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && phase_en == '0) |=> $stable(par_out) && $stable(bridge)); // R7

    AST_BRIDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rst && phase_en[0]) |=> $stable(par_out)); // R3

    AST_BRIDGE_GRABS_TAIL: assert property (@(posedge clk) disable iff (rst)
        (!rst && phase_en[0]) |=> bridge[0] == $past(par_out[SEG_BITS-1])); // R3

    AST_TAIL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!rst && !phase_en[1]) |=> $stable(ser_out)); // R1

    AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!rst && phase_en[SEG_BITS]) |=> par_out[0] == $past(ser_in)); // R5

    AST_INNER_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!rst && phase_en[SEG_BITS-1]) |=> par_out[1] == $past(par_out[0])); // R4

    if (NUM_SEGS > 1) begin : g_multi
        AST_BRIDGE_FEEDS_HEAD: assert property (@(posedge clk) disable iff (rst)
            (!rst && phase_en[SEG_BITS]) |=> par_out[SEG_BITS] == $past(bridge[0])); // R5
    end
endmodule

bind seg_shift_chain seg_shift_chain_chk #(
    .SEG_BITS(SEG_BITS),
    .NUM_SEGS(NUM_SEGS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .phase_en (phase_en),
    .par_out  (par_out),
    .ser_out  (ser_out),
    .bridge   (bridge)
);

// File: tb/test_seg_shift_chain.sv
module test_seg_shift_chain;
    localparam int SB  = 4;
    localparam int NS  = 128;
    localparam int TOT = SB * NS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ser_in = 1'b0;
    logic [SB:0]    phase_en = '0;
    logic [TOT-1:0] par_out;
    logic           ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [TOT-1:0] model;

    seg_shift_chain #(.SEG_BITS(SB), .NUM_SEGS(NS)) i_seg_shift_chain (
        .clk(clk), .rst(rst), .ser_in(ser_in), .phase_en(phase_en),
        .par_out(par_out), .ser_out(ser_out)
    );

    always #4 clk = ~clk;

    task automatic cmp(input logic [TOT-1:0] exp, input string req);
        checks++;
        if (par_out !== exp || ser_out !== exp[TOT-1]) begin
            errors++;
            $display("FAIL %s: par_out=%h ser_out=%b expected par_out=%h ser_out=%b",
                     req, par_out, ser_out, exp, exp[TOT-1]);
        end
    endtask

    // Drive one cycle's inputs (at a falling edge) and return at the next falling edge.
    task automatic apply(input logic [SB:0] en, input logic si);
        phase_en = en;
        ser_in   = si;
        @(posedge clk);
        @(negedge clk);
        phase_en = '0;
    endtask

    // Expected chain after the bridge phase plus `done` data phases of an ordered step.
    function automatic logic [TOT-1:0] partial(input logic [TOT-1:0] old, input logic si,
                                               input int done);
        logic [TOT-1:0] e;
        for (int g = 0; g < TOT; g++) begin
            if ((g % SB) >= SB - done) e[g] = (g == 0) ? si : old[g-1];
            else                       e[g] = old[g];
        end
        return e;
    endfunction

    task automatic full_step(input logic si, input bit gaps);
        logic [TOT-1:0] old;
        old = model;
        apply(1, ~si);
        cmp(old, "R3");
        for (int j = 1; j <= SB; j++) begin
            if (gaps) begin
                apply('0, ~si);
                cmp(partial(old, si, j - 1), "R7");
            end
            apply(1 << j, (j == SB) ? si : ~si);
            if (j == SB) cmp(partial(old, si, j), "R6");
            else         cmp(partial(old, si, j), "R4");
        end
        model = {model[TOT-2:0], si};
        cmp(model, "R5");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp('0, "R8");

        // R1: a single 1 walks to the serial output after TOT steps.
        full_step(1'b1, 1'b0);
        for (int n = 1; n < TOT; n++) full_step(1'b0, 1'b0);
        checks++;
        if (ser_out !== 1'b1) begin
            errors++;
            $display("FAIL R1: ser_out=%b expected 1", ser_out);
        end

        // Irregular traffic, some steps with idle gaps.
        for (int n = 0; n < 300; n++) full_step(1'($urandom), (n % 7) == 3);

        // R7: idle cycles with toggling serial input.
        for (int n = 0; n < 4; n++) begin
            apply('0, n[0]);
            cmp(model, "R7");
        end

        // R4: lone middle-phase pulse moves only data bit 2 of each segment.
        begin
            logic [TOT-1:0] e;
            e = model;
            for (int g = 0; g < TOT; g++) if ((g % SB) == 2) e[g] = model[g-1];
            apply(1 << (SB - 2), 1'b1);
            cmp(e, "R4");
            model = e;
        end

        // Load the bridges, then hit reset together with the head phase.
        for (int n = 0; n < 20; n++) full_step(1'b1, 1'b0);
        apply(1, 1'b0);
        cmp(model, "R3");
        rst = 1'b1;
        apply(1 << SB, 1'b1);
        rst = 1'b0;
        model = '0;
        cmp(model, "R8");

        // R8: the bridges were cleared, so only segment 0's head picks up a 1.
        apply(1 << SB, 1'b1);
        model[0] = 1'b1;
        cmp(model, "R8");

        for (int n = 0; n < 10; n++) full_step(1'($urandom), 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule